// File: doc/BRIEF.md
# Multi-Drive Seek Status Tracker

This block holds one pending seek-completion status and one present-cylinder value for each of four floppy drive slots. Recalibrate and seek command strobes, each with a 2-bit drive number (and, for a seek, a target cylinder), update the addressed slot. They also raise an interrupt line. The block's inputs also include a media-present flag and a maximum-track value for each drive.

A sense-interrupt strobe drains the pending statuses one at a time, always taking the lowest-numbered slot that has something pending. The reply is either two bytes or one byte:

- **Two bytes:** the status byte (the pending flags ORed with the drive number), then that drive's cylinder.
- **One byte:** a single invalid-command byte, when nothing is pending.

Each reply is loaded into a two-entry output buffer. The host reads the buffer one byte at a time with a pop strobe.

The parameter `NUM_DRIVES` (at most 4) sets how many slots map to attached drives. A command aimed at a slot at or above that count is recorded as a not-ready failure.

Top module: `seek_status_tracker`

## Requirements
- R1: Reset leaves every slot with no pending status and cylinder 0. It also leaves the interrupt low and the output buffer empty (`rsp_valid_o` = 0).
- R2: A recalibrate on an attached drive sets its cylinder to 0. With media present it leaves no pending status.
- R3: A recalibrate on an attached drive without media sets its cylinder to 0 and its pending status to 0x68 (abnormal 0x40 | seek end 0x20 | not-ready 0x08).
- R4: A seek on an attached drive whose target is not above that drive's maximum track loads the target into the cylinder and sets the pending status to 0x20.
- R5: A seek on an attached drive whose target is above its maximum track keeps the cylinder and sets the pending status to 0x60.
- R6: A seek or recalibrate on a drive number >= `NUM_DRIVES` sets that slot's pending status to 0x68 and keeps its cylinder.
- R7: A sense command picks the lowest drive number with a nonzero pending status. It loads the bytes {status | drive number in bits 1:0, cylinder} and clears only that slot's status.
- R8: A sense command with nothing pending loads the single byte 0x80 and drives the interrupt low.
- R9: Every seek or recalibrate drives the interrupt high in the cycle after its strobe.
- R10: The output buffer presents its bytes in load order, one per pop. `rsp_valid_o` is high while a byte remains. A pop on an empty buffer has no effect.
- R11: A sense command that finds a pending status leaves the interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| recal_i | input | 1 | Recalibrate strobe |
| seek_i | input | 1 | Seek strobe |
| drv_i | input | 2 | Drive number for the command |
| target_i | input | CYL_W | Seek target cylinder |
| media_i | input | 4 | Media-present flag per drive |
| max_track_i | input | 4*CYL_W | Maximum track per drive, drive d at bits [d*CYL_W +: CYL_W] |
| sense_i | input | 1 | Sense-interrupt strobe |
| rsp_pop_i | input | 1 | Consume the current response byte |
| rsp_valid_o | output | 1 | A response byte is available |
| rsp_byte_o | output | 8 | Current response byte |
| irq_o | output | 1 | Interrupt line |

## Verification
The embedded properties assume that at most one of recalibrate, seek and sense is strobed in any cycle. They also assume that the maximum-track and media inputs stay steady while a command is applied. The stimulus issues each command as an isolated one-cycle strobe, with settle gaps between commands, and changes the per-drive configuration only between commands. Under that discipline, a clear by a sense command never collides with an update to the same slot.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned SLOTS = 4;
  localparam logic [7:0] ST_NOTRDY = 8'h08;
  localparam logic [7:0] ST_SEEKEND = 8'h20;
  localparam logic [7:0] ST_ABNORMAL = 8'h40;
  localparam logic [7:0] ST_INVALID = 8'h80;
  localparam logic [7:0] ST_FAULT = ST_ABNORMAL | ST_SEEKEND | ST_NOTRDY;
  localparam logic [7:0] ST_RANGE = ST_ABNORMAL | ST_SEEKEND;
endpackage

// File: rtl/sst_drive_slot.sv
module sst_drive_slot
  import sst_pkg::*;
#(
  parameter int unsigned CYL_W = 8,
  parameter bit IN_RANGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recal_hit,
  input  logic             seek_hit,
  input  logic             media,
  input  logic [CYL_W-1:0] target,
  input  logic [CYL_W-1:0] max_track,
  input  logic             clr,
  output logic [7:0]       result_o,
  output logic [CYL_W-1:0] cyl_o
);
  logic [7:0]       res_q, res_d;
  logic [CYL_W-1:0] cyl_q, cyl_d;
  logic             res_en, cyl_en, over;

  always_comb begin
    over   = target > max_track;
    res_en = recal_hit | seek_hit | clr;
    cyl_en = IN_RANGE && (recal_hit || (seek_hit && !over));
    res_d  = 8'h00;
    if (recal_hit) begin
      res_d = (IN_RANGE && media) ? 8'h00 : ST_FAULT;
    end else if (seek_hit) begin
      if (!IN_RANGE)  res_d = ST_FAULT;
      else if (over)  res_d = ST_RANGE;
      else            res_d = ST_SEEKEND;
    end
    cyl_d = recal_hit ? '0 : target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= 8'h00;
      cyl_q <= '0;
    end else begin
      if (res_en) res_q <= res_d;
      if (cyl_en) cyl_q <= cyl_d;
    end
  end

  assign result_o = res_q;
  assign cyl_o    = cyl_q;

  // R5 / R6: a rejected seek never moves the cylinder
  a_r5_cyl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_hit && (over || !IN_RANGE)) |=> $stable(cyl_q));
  // R4: an accepted seek loads its target
  a_r4_seek_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (IN_RANGE && seek_hit && !over) |=> (cyl_q == $past(target)));
  // R7: a clear by sense empties the slot
  a_r7_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !recal_hit && !seek_hit) |=> (res_q == 8'h00));
endmodule

// File: rtl/sst_sense_arbiter.sv
module sst_sense_arbiter
  import sst_pkg::*;
(
  input  logic [SLOTS-1:0] pend_i,
  output logic             found_o,
  output logic [1:0]       idx_o,
  output logic [SLOTS-1:0] sel_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = 2'd0;
    sel_o   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        idx_o   = 2'(i);
      end
    end
    if (found_o) sel_o[idx_o] = 1'b1;
  end

  // R7: the choice is one slot at most
  always_comb begin
    a_r7_one_choice: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/sst_rsp_buffer.sv
module sst_rsp_buffer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_two,
  input  logic       load_one,
  input  logic [7:0] byte0,
  input  logic [7:0] byte1,
  input  logic       pop,
  output logic       valid_o,
  output logic [7:0] data_o
);
  logic [1:0] cnt_q, cnt_d;
  logic [7:0] d0_q, d0_d, d1_q, d1_d;
  logic       en;

  always_comb begin
    cnt_d = cnt_q;
    d0_d  = d0_q;
    d1_d  = d1_q;
    en    = 1'b0;
    if (load_two || load_one) begin
      en    = 1'b1;
      cnt_d = load_two ? 2'd2 : 2'd1;
      d0_d  = byte0;
      d1_d  = byte1;
    end else if (pop && cnt_q != 2'd0) begin
      en    = 1'b1;
      cnt_d = cnt_q - 2'd1;
      d0_d  = d1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      d0_q  <= 8'h00;
      d1_q  <= 8'h00;
    end else if (en) begin
      cnt_q <= cnt_d;
      d0_q  <= d0_d;
      d1_q  <= d1_d;
    end
  end

  assign valid_o = cnt_q != 2'd0;
  assign data_o  = d0_q;

  a_r10_two_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load_two |=> (cnt_q == 2'd2));
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == 2'd0 && !load_two && !load_one) |=> (cnt_q == 2'd0));
  a_r10_never_three: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'd3);
endmodule

// File: rtl/seek_status_tracker.sv
module seek_status_tracker
  import sst_pkg::*;
#(
  parameter int unsigned NUM_DRIVES = 3,
  parameter int unsigned CYL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   recal_i,
  input  logic                   seek_i,
  input  logic [1:0]             drv_i,
  input  logic [CYL_W-1:0]       target_i,
  input  logic [SLOTS-1:0]       media_i,
  input  logic [SLOTS*CYL_W-1:0] max_track_i,
  input  logic                   sense_i,
  input  logic                   rsp_pop_i,
  output logic                   rsp_valid_o,
  output logic [7:0]             rsp_byte_o,
  output logic                   irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [7:0]       res_w [SLOTS];
  logic [CYL_W-1:0] cyl_w [SLOTS];
  logic [SLOTS-1:0] pend, sel;
  logic             found;
  logic [1:0]       idx;
  logic             irq_q, irq_d, irq_en;
  logic [7:0]       b0, b1;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    sst_drive_slot #(
      .CYL_W(CYL_W),
      .IN_RANGE(g < NUM_DRIVES)
    ) u_slot (
      .clk(clk),
      .rst_n(rst_n),
      .recal_hit(recal_i && drv_i == 2'(g)),
      .seek_hit(seek_i && drv_i == 2'(g)),
      .media(media_i[g]),
      .target(target_i),
      .max_track(max_track_i[g*CYL_W +: CYL_W]),
      .clr(sense_i && sel[g]),
      .result_o(res_w[g]),
      .cyl_o(cyl_w[g])
    );
    assign pend[g] = res_w[g] != 8'h00;
  end

  sst_sense_arbiter u_arb (
    .pend_i(pend),
    .found_o(found),
    .idx_o(idx),
    .sel_o(sel)
  );

  always_comb begin
    b0 = found ? (res_w[idx] | {6'd0, idx}) : ST_INVALID;
    b1 = 8'(cyl_w[idx]);
    irq_en = recal_i | seek_i | (sense_i & ~found);
    irq_d  = recal_i | seek_i;
  end

  sst_rsp_buffer u_buf (
    .clk(clk),
    .rst_n(rst_n),
    .load_two(sense_i && found),
    .load_one(sense_i && !found),
    .byte0(b0),
    .byte1(b1),
    .pop(rsp_pop_i),
    .valid_o(rsp_valid_o),
    .data_o(rsp_byte_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // Input discipline: one command strobe per cycle at most
  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({recal_i, seek_i, sense_i}));
  a_r9_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (recal_i || seek_i) |=> irq_o);
  a_r8_irq_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && pend == '0) |=> !irq_o);
  a_r11_irq_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && pend != '0) |=> $stable(irq_o));
  a_r8_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && pend == '0) |=> (rsp_valid_o && rsp_byte_o == ST_INVALID));
endmodule

// File: tb/tb_seek_status_tracker.sv
`timescale 1ns/1ps
module tb_seek_status_tracker;
  localparam int ND = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          recal_i, seek_i, sense_i, rsp_pop_i;
  logic [1:0]    drv_i;
  logic [CW-1:0] target_i;
  logic [3:0]    media_i;
  logic [4*CW-1:0] max_track_i;
  logic          rsp_valid_o, irq_o;
  logic [7:0]    rsp_byte_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_res [4];
  logic [7:0] m_cyl [4];
  logic [7:0] m_max [4];

  always #4 clk = ~clk;

  seek_status_tracker #(.NUM_DRIVES(ND), .CYL_W(CW)) dut (
    .clk(clk), .rst_ni(rst_ni), .recal_i(recal_i), .seek_i(seek_i),
    .drv_i(drv_i), .target_i(target_i), .media_i(media_i),
    .max_track_i(max_track_i), .sense_i(sense_i), .rsp_pop_i(rsp_pop_i),
    .rsp_valid_o(rsp_valid_o), .rsp_byte_o(rsp_byte_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic set_max(input int d, input logic [7:0] v);
    m_max[d] = v;
    max_track_i[d*CW +: CW] = v;
  endtask

  task automatic cmd(input bit is_seek, input int d, input logic [7:0] tgt);
    @(negedge clk);
    drv_i = 2'(d); target_i = tgt;
    if (is_seek) seek_i = 1'b1; else recal_i = 1'b1;
    @(negedge clk);
    seek_i = 1'b0; recal_i = 1'b0;
    if (d >= ND) m_res[d] = 8'h68;
    else if (!is_seek) begin
      m_cyl[d] = 8'h00;
      m_res[d] = media_i[d] ? 8'h00 : 8'h68;
    end else if (tgt > m_max[d]) m_res[d] = 8'h60;
    else begin
      m_cyl[d] = tgt;
      m_res[d] = 8'h20;
    end
    chk("R9 irq after command", {7'd0, irq_o}, 8'h01);
  endtask

  task automatic pop();
    @(negedge clk); rsp_pop_i = 1'b1;
    @(negedge clk); rsp_pop_i = 1'b0;
  endtask

  // issues one sense and checks the reply against the model; returns 1 if a status was found
  task automatic sense(output bit hit);
    int f = -1;
    logic irq_before;
    for (int i = 3; i >= 0; i--) if (m_res[i] != 8'h00) f = i;
    irq_before = irq_o;
    @(negedge clk); sense_i = 1'b1;
    @(negedge clk); sense_i = 1'b0;
    chk("R10 valid after sense", {7'd0, rsp_valid_o}, 8'h01);
    if (f >= 0) begin
      hit = 1'b1;
      chk("R7 status byte", rsp_byte_o, m_res[f] | 8'(f));
      chk("R11 irq kept", {7'd0, irq_o}, {7'd0, irq_before});
      pop();
      chk("R10 second byte pending", {7'd0, rsp_valid_o}, 8'h01);
      chk("R7 cylinder byte", rsp_byte_o, m_cyl[f]);
      m_res[f] = 8'h00;
    end else begin
      hit = 1'b0;
      chk("R8 invalid byte", rsp_byte_o, 8'h80);
      chk("R8 irq low", {7'd0, irq_o}, 8'h00);
    end
    pop();
    chk("R10 drained", {7'd0, rsp_valid_o}, 8'h00);
  endtask

  task automatic drain();
    bit h;
    h = 1'b1;
    while (h) sense(h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit h;
    logic [7:0] tg [9];
    tg = '{8'd0, 8'd5, 8'd10, 8'd11, 8'd40, 8'd41, 8'd79, 8'd80, 8'd255};
    rst_ni = 1'b0; recal_i = 0; seek_i = 0; sense_i = 0; rsp_pop_i = 0;
    drv_i = 0; target_i = 0; media_i = 4'b0101; max_track_i = '0;
    set_max(0, 8'd79); set_max(1, 8'd40); set_max(2, 8'd10); set_max(3, 8'd50);
    for (int i = 0; i < 4; i++) begin m_res[i] = 0; m_cyl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq low after reset", {7'd0, irq_o}, 8'h00);
    chk("R1 buffer empty after reset", {7'd0, rsp_valid_o}, 8'h00);
    sense(h);
    chk("R1 nothing pending after reset", {7'd0, h}, 8'h00);
    pop();
    chk("R10 pop on empty ignored", {7'd0, rsp_valid_o}, 8'h00);

    // R2 R3 R6: recalibrate every slot, then drain in drive order (R7)
    for (int d = 0; d < 4; d++) cmd(1'b0, d, 8'h00);
    drain();

    // R4 R5 R6: sweep targets over every slot, one pending at a time
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 9; k++) begin
        cmd(1'b1, d, tg[k]);
        sense(h);
        chk("R4 R5 R6 one status pending", {7'd0, h}, 8'h01);
        sense(h);
      end

    // R2: recalibrate with media returns the cylinder to 0, seen via a rejected seek
    cmd(1'b1, 0, 8'd40);
    drain();
    cmd(1'b0, 0, 8'h00);
    sense(h);
    chk("R2 recal with media leaves nothing", {7'd0, h}, 8'h00);
    cmd(1'b1, 0, 8'd200);
    drain();

    // R7 R11: several pending, drained lowest first with irq held
    cmd(1'b1, 2, 8'd3);
    cmd(1'b1, 0, 8'd7);
    cmd(1'b0, 3, 8'h00);
    cmd(1'b1, 1, 8'd90);
    drain();

    // media changes between commands
    media_i = 4'b1010;
    for (int d = 0; d < 4; d++) cmd(1'b0, d, 8'h00);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule